// File: doc/BRIEF.md
# Compare Flags and Branch Evaluator

This block performs the compare half of a conditional branch. On a compare strobe it subtracts operand B from operand A, at either byte or word width, and stores four condition flags in a small register: negative, zero, overflow and borrow. Only the flag register is written. The operands are not changed and nothing else is stored.

A 4-bit condition selector picks one branch predicate, which is evaluated from the stored flags. The predicates cover single-flag tests, unsigned orderings and signed orderings. When the predicate holds, the next program counter is the incoming program counter plus a sign-extended 8-bit displacement. The incoming value must already point past the branch instruction. When the predicate does not hold, the incoming value is passed through.

The surrounding fetch and decode logic supplies the operands, the strobe, the selector, the displacement and the program counter. Fetch, decode and memory access sit outside this block.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is asserted (rst_n low), all four flags read 0.
- R2: A rising clock edge with cmp_en high loads flag_c with the borrow of op_a minus op_b, treated as unsigned at the selected width. flag_c is 1 exactly when op_a < op_b. With cmp_en low, that edge loads nothing.
- R3: The same compare loads flag_v with 1 exactly when the two's-complement difference at the selected width overflows. This is the case when the carry into the MSB differs from the carry out of it. Example: byte $80 minus $7F gives V=1, N=0, C=0, Z=0.
- R4: The same compare loads flag_n with the MSB of the truncated difference. It loads flag_z with 1 exactly when the truncated difference is all zeros.
- R5: When wide_sel is 0, the compare uses bits 7:0 of both operands, takes bit 7 as the MSB, and ignores bits 15:8. When wide_sel is 1, it uses all 16 bits and takes bit 15 as the MSB.
- R6: On an edge with cmp_en low, the flags keep their values whatever the operands are.
- R7: The single-flag codes on cond_sel drive br_taken as follows. 0 is always taken. 1 is Z=1 and 2 is Z=0. 3 is N=1 and 4 is N=0. 5 is V=1 and 6 is V=0. 7 is C=1 and 8 is C=0.
- R8: The unsigned codes drive br_taken as follows. 9 (higher) is taken when (C OR Z)=0. 10 (lower or same) is taken when (C OR Z)=1.
- R9: The signed codes drive br_taken as follows. 11 (greater or equal) is taken when (N XOR V)=0. 12 (less) is taken when (N XOR V)=1. 13 (greater) is taken when Z OR (N XOR V)=0. 14 (less or equal) is taken when Z OR (N XOR V)=1.
- R10: Code 15 is never taken.
- R11: When br_taken is 1, pc_next equals pc_in plus disp sign-extended to 16 bits, modulo 2^16. Example: pc_in $E00A with disp $FE gives $E008.
- R12: When br_taken is 0, pc_next equals pc_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en | input | 1 | Compare strobe; loads the flags on the clock edge |
| wide_sel | input | 1 | 1 selects a 16-bit compare; 0 selects an 8-bit compare |
| op_a | input | 16 | Minuend |
| op_b | input | 16 | Subtrahend |
| cond_sel | input | 4 | Branch condition code |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | 16 | Program counter, already past the branch instruction |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Borrow flag |
| br_taken | output | 1 | The selected predicate holds |
| pc_next | output | 16 | Branch target or pass-through program counter |

## Verification
The flags come from a register, so a compare becomes visible one clock edge after its strobe is sampled. br_taken and pc_next follow the stored flags, cond_sel, disp and pc_in combinationally, with no added cycle. The bench applies each compare before a rising edge and reads the flags shortly after that edge. While the flags are still stable, it steps cond_sel through all sixteen codes in short sub-cycle steps, so every predicate and target is read within the cycle in which it is due. For the hold requirement, the bench changes the operands with the strobe low, lets several edges pass, and reads the flags again.

// File: rtl/cmpbr_pkg.sv
`timescale 1ns/1ps
package cmpbr_pkg;

  typedef enum logic [3:0] {
    CND_ALW  = 4'd0,
    CND_EQ   = 4'd1,
    CND_NE   = 4'd2,
    CND_MI   = 4'd3,
    CND_PL   = 4'd4,
    CND_VS   = 4'd5,
    CND_VC   = 4'd6,
    CND_CS   = 4'd7,
    CND_CC   = 4'd8,
    CND_HI   = 4'd9,
    CND_LS   = 4'd10,
    CND_GE   = 4'd11,
    CND_LT   = 4'd12,
    CND_GT   = 4'd13,
    CND_LE   = 4'd14,
    CND_NONE = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

endpackage

// File: rtl/cmpbr_flag_unit.sv
`timescale 1ns/1ps
module cmpbr_flag_unit
  import cmpbr_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              wide_sel,
  input  logic [WIDE_W-1:0] op_a,
  input  logic [WIDE_W-1:0] op_b,
  output flags_t            flags_q
);

  // Flags of a subtraction from its sign bits, borrow and zero test.
  function automatic flags_t sub_flags(input logic a_msb, input logic b_msb,
                                       input logic r_msb, input logic borrow,
                                       input logic zero);
    flags_t f;
    f.n = r_msb;
    f.z = zero;
    f.v = (a_msb ^ b_msb) & (r_msb ^ a_msb);
    f.c = borrow;
    return f;
  endfunction

  logic [WIDE_W:0]   diff_wide;
  logic [NARROW_W:0] diff_narrow;
  flags_t            wide_flags;
  flags_t            narrow_flags;
  flags_t            cmp_flags;

  assign diff_wide   = {1'b0, op_a} - {1'b0, op_b};
  assign diff_narrow = {1'b0, op_a[NARROW_W-1:0]} - {1'b0, op_b[NARROW_W-1:0]};

  assign wide_flags = sub_flags(op_a[WIDE_W-1], op_b[WIDE_W-1],
                                diff_wide[WIDE_W-1], diff_wide[WIDE_W],
                                diff_wide[WIDE_W-1:0] == '0);
  assign narrow_flags = sub_flags(op_a[NARROW_W-1], op_b[NARROW_W-1],
                                  diff_narrow[NARROW_W-1], diff_narrow[NARROW_W],
                                  diff_narrow[NARROW_W-1:0] == '0);

  assign cmp_flags = wide_sel ? wide_flags : narrow_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (cmp_en) flags_q <= cmp_flags;
  end

  // R6
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(flags_q));

  // R4
  zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.z |-> (!flags_q.n && !flags_q.v && !flags_q.c));

  // R3
  ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.v |-> (flags_q.c == flags_q.n));

endmodule

// File: rtl/cmpbr_cond_eval.sv
`timescale 1ns/1ps
module cmpbr_cond_eval
  import cmpbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  flags_t flags,
  input  cond_e  cond,
  output logic   taken
);

  function automatic logic eval_pred(input flags_t f, input cond_e c);
    logic lt_s;
    lt_s = f.n ^ f.v;
    case (c)
      CND_ALW: return 1'b1;
      CND_EQ:  return f.z;
      CND_NE:  return !f.z;
      CND_MI:  return f.n;
      CND_PL:  return !f.n;
      CND_VS:  return f.v;
      CND_VC:  return !f.v;
      CND_CS:  return f.c;
      CND_CC:  return !f.c;
      CND_HI:  return !(f.c | f.z);
      CND_LS:  return f.c | f.z;
      CND_GE:  return !lt_s;
      CND_LT:  return lt_s;
      CND_GT:  return !(f.z | lt_s);
      CND_LE:  return f.z | lt_s;
      default: return 1'b0;
    endcase
  endfunction

  assign taken = eval_pred(flags, cond);

  // R7
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == CND_ALW) |-> taken);

  // R10
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == CND_NONE) |-> !taken);

  // R8
  hi_ls_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == CND_HI && taken) |-> (!flags.c && !flags.z));

endmodule

// File: rtl/cmpbr_target_calc.sv
`timescale 1ns/1ps
module cmpbr_target_calc #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target
);

  localparam int EXT_W = PC_W - DISP_W;

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] pc,
                                                 input logic [DISP_W-1:0] d);
    logic [PC_W-1:0] d_ext;
    d_ext = {{EXT_W{d[DISP_W-1]}}, d};
    return pc + d_ext;
  endfunction

  assign target = rel_target(pc_in, disp);

endmodule

// File: rtl/cmp_branch_unit.sv
`timescale 1ns/1ps
module cmp_branch_unit
  import cmpbr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PC_W     = 16,
  parameter int DISP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        cond_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c,
  output logic              br_taken,
  output logic [PC_W-1:0]   pc_next
);

  localparam int HALF_RANGE = 1 << (DISP_W - 1);

  flags_t          flags_q;
  logic            pred_hit;
  logic [PC_W-1:0] target_pc;
  logic [PC_W-1:0] pc_delta;

  cmpbr_flag_unit #(.WIDE_W(DATA_W), .NARROW_W(NARROW_W)) flag_u (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .wide_sel(wide_sel),
    .op_a(op_a), .op_b(op_b), .flags_q(flags_q)
  );

  cmpbr_cond_eval cond_u (
    .clk(clk), .rst_n(rst_n), .flags(flags_q),
    .cond(cond_e'(cond_sel)), .taken(pred_hit)
  );

  cmpbr_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W)) tgt_u (
    .pc_in(pc_in), .disp(disp), .target(target_pc)
  );

  assign flag_n   = flags_q.n;
  assign flag_z   = flags_q.z;
  assign flag_v   = flags_q.v;
  assign flag_c   = flags_q.c;
  assign br_taken = pred_hit;
  assign pc_next  = pred_hit ? target_pc : pc_in;
  assign pc_delta = pc_next - pc_in;

  // R12
  not_taken_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> (pc_next == pc_in));

  // R11
  fwd_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !disp[DISP_W-1]) |-> (pc_delta < PC_W'(HALF_RANGE)));

  // R11
  back_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && disp[DISP_W-1]) |-> (pc_delta >= PC_W'(-HALF_RANGE)));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_flags_chk: assert ({flag_n, flag_z, flag_v, flag_c} == 4'b0);

endmodule

// File: tb/cmp_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_en = 1'b0;
  logic        wide_sel = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic [3:0]  cond_sel = '0;
  logic [7:0]  disp = '0;
  logic [15:0] pc_in = '0;
  logic        flag_n, flag_z, flag_v, flag_c, br_taken;
  logic [15:0] pc_next;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cmp_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .wide_sel(wide_sel),
    .op_a(op_a), .op_b(op_b), .cond_sel(cond_sel), .disp(disp),
    .pc_in(pc_in), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c), .br_taken(br_taken), .pc_next(pc_next)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Reference condition results computed from operand arithmetic: {n,z,v,c}
  function automatic logic [3:0] ref_flags(input logic [15:0] a, input logic [15:0] b,
                                           input logic wide);
    int w, half, ua, ub, sa, sb, sd, ud;
    w    = wide ? 16 : 8;
    half = 1 << (w - 1);
    ua   = wide ? int'(a) : int'(a[7:0]);
    ub   = wide ? int'(b) : int'(b[7:0]);
    sa   = (ua >= half) ? ua - 2 * half : ua;
    sb   = (ub >= half) ? ub - 2 * half : ub;
    sd   = sa - sb;
    ud   = (ua - ub + 2 * half) % (2 * half);
    return {ud >= half, ua == ub, (sd >= half) || (sd < -half), ua < ub};
  endfunction

  function automatic logic ref_taken(input logic [3:0] f, input int c);
    logic n, z, v, cy;
    {n, z, v, cy} = f;
    case (c)
      0: return 1'b1;
      1: return z;
      2: return !z;
      3: return n;
      4: return !n;
      5: return v;
      6: return !v;
      7: return cy;
      8: return !cy;
      9: return !cy && !z;
      10: return cy || z;
      11: return n == v;
      12: return n != v;
      13: return !z && (n == v);
      14: return z || (n != v);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_req(input int c);
    if (c <= 8) return "R7";
    if (c <= 10) return "R8";
    if (c <= 14) return "R9";
    return "R10";
  endfunction

  task automatic sweep_conds(input logic [3:0] f);
    logic [15:0] tgt;
    tgt = pc_in + {{8{disp[7]}}, disp};
    for (int c = 0; c < 16; c++) begin
      logic t;
      cond_sel = 4'(c);
      #0.1;
      t = ref_taken(f, c);
      chk(cond_req(c), {31'd0, br_taken}, {31'd0, t});
      if (t) chk("R11", {16'd0, pc_next}, {16'd0, tgt});
      else   chk("R12", {16'd0, pc_next}, {16'd0, pc_in});
    end
  endtask

  task automatic do_cmp(input logic [15:0] a, input logic [15:0] b, input logic wide,
                        input string req);
    logic [3:0] f;
    @(negedge clk);
    op_a = a; op_b = b; wide_sel = wide; cmp_en = 1'b1;
    pc_in = a ^ {b[7:0], b[15:8]};
    disp = a[7:0] + b[7:0];
    @(posedge clk);
    #1;
    cmp_en = 1'b0;
    f = ref_flags(a, b, wide);
    chk(req, {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, f});
    sweep_conds(f);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0]  held;
    logic [31:0] lcg;
    // R1: flags clear in reset, and predicates follow all-zero flags
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    op_a = 16'h1234; op_b = 16'h0034; cmp_en = 1'b1; // strobe ignored in reset
    @(posedge clk);
    #1;
    chk("R1", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    sweep_conds(4'b0000);

    // R3: byte $80 minus $7F
    do_cmp(16'h0080, 16'h007F, 1'b0, "R3");
    chk("R3", {28'd0, flag_n, flag_z, flag_v, flag_c}, 32'h2);

    // R2 R3 R4 R5: exhaustive byte compares with junk in the upper bytes
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        do_cmp({8'(a * 7 + b * 3), 8'(a)}, {8'(b * 5 + a), 8'(b)}, 1'b0, "R2 R3 R4 R5");

    // R5: word corner cases
    do_cmp(16'h8000, 16'h7FFF, 1'b1, "R3 R5");
    do_cmp(16'h7FFF, 16'h8000, 1'b1, "R3 R5");
    do_cmp(16'h0000, 16'h0001, 1'b1, "R2 R5");
    do_cmp(16'hFFFF, 16'hFFFF, 1'b1, "R4 R5");
    do_cmp(16'h0100, 16'h0000, 1'b1, "R4 R5");
    do_cmp(16'h0100, 16'h0001, 1'b1, "R2 R5");

    // R2 R3 R4: pseudo-random word compares
    lcg = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_cmp(lcg[31:16], lcg[15:0] ^ lcg[23:8], 1'b1, "R2 R3 R4");
    end

    // R6: flags hold while the strobe is low
    for (int k = 0; k < 8; k++) begin
      do_cmp(16'h00F2 + 16'(k), 16'h00FF - 16'(k * 9), k[0], "R6");
      held = {flag_n, flag_z, flag_v, flag_c};
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        op_a = 16'(j * 4099 + k); op_b = 16'(k * 777 + 3); wide_sel = j[0];
        @(posedge clk);
        #1;
        chk("R6", {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, held});
      end
    end

    // R11: branch to itself and wrap-around targets with code 0
    @(negedge clk);
    cond_sel = 4'd0; pc_in = 16'hE00A; disp = 8'hFE;
    #1;
    chk("R11", {16'd0, pc_next}, 32'h0000E008);
    pc_in = 16'hFFF0; disp = 8'h20;
    #1;
    chk("R11", {16'd0, pc_next}, 32'h00000010);
    pc_in = 16'h0005; disp = 8'h80;
    #1;
    chk("R11", {16'd0, pc_next}, 32'h0000FF85);
    // R11 R12: every displacement, taken and not taken
    for (int d = 0; d < 256; d++) begin
      logic [15:0] e;
      pc_in = 16'h4000 + 16'(d * 37);
      disp = 8'(d);
      e = pc_in + {{8{disp[7]}}, disp};
      cond_sel = 4'd0;
      #0.2;
      chk("R11", {16'd0, pc_next}, {16'd0, e});
      cond_sel = 4'd15;
      #0.2;
      chk("R12", {16'd0, pc_next}, {16'd0, pc_in});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule